// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital half of a 14-bit voltage-output converter. A host writes it through three wires: an active-low select, a serial clock and a data line. Every frame carries a two-bit opcode above a data field. The block keeps two code registers, a staging register and the register that drives the converter. A frame can fill the staging register alone, move the staging register into the converter register, or write both at once.

The opcode value that is all ones opens a control space. This space sets a general-purpose output pin, picks the clock edge on which the daisy-chain output moves, and requests power-down. Power-down can also come from a hardware pin. It is gated by a lockout input, and a falling edge on that input releases it. An active-low clear pin puts the converter register back to a strap-selected reset code.

All pins are sampled in the system clock domain. They first pass through a synchronizer of parameterizable depth, and edges are then detected on the synchronized copies. The serial clock must therefore run well below the system clock.

Top module: `serdac_frontend`

## Requirements
- R1: A frame is DATA_W+2 bits (16 by default), sent MSB first. The top two bits are the opcode and the low DATA_W bits are data. A bit is taken on a rising edge of `sclk` only while `cs_n` is low. Clock edges seen while `cs_n` is high are ignored.
- R2: A frame runs on the rising edge of `cs_n`, and only if the number of bits taken is a non-zero multiple of the frame length. In that case the last frame length of bits is used. Any other count is discarded. The bits may arrive in several bursts, as long as `cs_n` stays low between them.
- R3: Opcode 00 writes the staging register and leaves `dac_code` unchanged.
- R4: Opcode 01 copies the staging register into the converter register and clears `shutdown`.
- R5: Opcode 10 writes the data field to both registers and clears `shutdown`.
- R6: Opcode 11 decodes the top data bits (bits 13..11 by default) as a sub-command. 00x is no operation. 01x is power-down, and it acts only while `pdl` is high. 100 drives `upo` low. 101 drives `upo` high.
- R7: Sub-command 110 selects the late output mode and 111 the early mode (the default). In early mode, `dout` takes the register MSB on each accepted rising `sclk` edge, so it lags `din` by one frame length of clocks. In late mode, `dout` takes the MSB on each falling `sclk` edge, which adds half a clock.
- R8: `shdn` high while `pdl` is high sets `shutdown`. Bringing `shdn` low does not clear it. While `pdl` is low, neither the hardware request nor the software request sets it.
- R9: A high-to-low transition on `pdl` clears `shutdown`.
- R10: While `shutdown` is set, frames are still received. Opcode 00 still fills the staging register. `dout` holds its level.
- R11: While `clr_n` is low, the converter register holds the reset code and `upo` is low. The reset code is 0 when `rs` is low and 2^(DATA_W-1) (0x2000 by default) when `rs` is high. The staging register keeps its contents.
- R12: After `rst_n`, both registers hold the reset code, `upo` and `dout` are low, early mode is selected and `shutdown` is clear. While a register holds the reset code, its value follows `rs`.
- R13: A change on any serial or control pin takes effect on the (SYNC_STAGES+1)-th rising `clk` edge after the pin is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock |
| din | input | 1 | Serial data in |
| shdn | input | 1 | Hardware power-down request |
| pdl | input | 1 | Power-down permit; a falling edge wakes the block |
| clr_n | input | 1 | Active-low clear to reset code |
| rs | input | 1 | Reset code select: 0 gives zero, 1 gives midscale |
| dac_code | output | DATA_W | Code driving the converter |
| shutdown | output | 1 | Power-down state |
| upo | output | 1 | General-purpose output level |
| dout | output | 1 | Daisy-chain serial output |

## Verification
The bench builds the block with DATA_W=14 and SYNC_STAGES=2, and drives `sclk` with four system clocks per phase. With two synchronizer stages, the three-edge latency of R13 is exercised. Because each phase lasts several cycles, the early and late `dout` timings fall on clearly different clocks, so the per-clock comparison can tell the two modes apart. The 14-bit data width places the sub-command on bits 13..11 of a 16-bit frame. Split bursts, short and long bit counts, and double frames can then be built with a 64-bit stimulus word.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

   typedef enum logic [1:0] {
      OP_LOAD_IN   = 2'b00,
      OP_UPDATE    = 2'b01,
      OP_LOAD_BOTH = 2'b10,
      OP_CTRL      = 2'b11
   } op_e;

   // pin bundle, order used for synchronization
   typedef struct packed {
      logic cs_n;
      logic sclk;
      logic din;
      logic shdn;
      logic pdl;
      logic clr_n;
   } pins_t;

   localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0,
                                   shdn: 1'b0, pdl: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
   parameter int             W      = 1,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serdac_rx.sv
module serdac_rx #(
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          cs_n_prv,
   input  logic          sclk,
   input  logic          sclk_prv,
   input  logic          din,
   input  logic          mode_late,
   input  logic          hold,
   output logic          frame_go,
   output logic [FW-1:0] word,
   output logic          dout
);

   localparam int CW = $clog2(FW);

   logic [FW-1:0] sr_q;
   logic [CW-1:0] cnt_q;
   logic          any_q;
   logic          dout_q;
   logic          rise, fall, cs_rise, shift;

   assign rise    = sclk & ~sclk_prv;
   assign fall    = ~sclk & sclk_prv;
   assign cs_rise = cs_n & ~cs_n_prv;
   assign shift   = ~cs_n & rise;

   assign frame_go = cs_rise & any_q & (cnt_q == '0);
   assign word     = sr_q;
   assign dout     = dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         cnt_q  <= '0;
         any_q  <= 1'b0;
         dout_q <= 1'b0;
      end else begin
         if (cs_n) begin
            cnt_q <= '0;
            any_q <= 1'b0;
         end else if (shift) begin
            sr_q  <= {sr_q[FW-2:0], din};
            any_q <= 1'b1;
            cnt_q <= (cnt_q == CW'(FW-1)) ? '0 : cnt_q + 1'b1;
         end
         if (!hold) begin
            if (!mode_late && shift)
               dout_q <= sr_q[FW-2];
            else if (mode_late && fall)
               dout_q <= sr_q[FW-1];
         end
      end
   end

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
   import serdac_pkg::*;
#(
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_go,
   input  logic [DATA_W+1:0] word,
   input  logic              pdl,
   input  logic              shdn,
   input  logic              pdl_fall,
   input  logic              clr_n,
   input  logic              rs,
   output logic [DATA_W-1:0] dac_code,
   output logic              shutdown,
   output logic              upo,
   output logic              mode_late
);

   localparam int FW = DATA_W + 2;
   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   logic [DATA_W-1:0] in_q, dac_q, rst_code, in_eff, data;
   logic              in_live, dac_live, sd_q, upo_q, late_q;
   op_e               op;
   logic [2:0]        sub;

   assign rst_code = rs ? MID : '0;
   assign in_eff   = in_live ? in_q : rst_code;
   assign data     = word[DATA_W-1:0];
   assign op       = op_e'(word[FW-1 -: 2]);
   assign sub      = word[DATA_W-1 -: 3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q     <= '0;
         in_live  <= 1'b0;
         dac_q    <= '0;
         dac_live <= 1'b0;
         sd_q     <= 1'b0;
         upo_q    <= 1'b0;
         late_q   <= 1'b0;
      end else begin
         if (frame_go) begin
            unique case (op)
               OP_LOAD_IN: begin
                  in_q    <= data;
                  in_live <= 1'b1;
               end
               OP_UPDATE: begin
                  dac_q    <= in_eff;
                  dac_live <= 1'b1;
                  sd_q     <= 1'b0;
               end
               OP_LOAD_BOTH: begin
                  in_q     <= data;
                  in_live  <= 1'b1;
                  dac_q    <= data;
                  dac_live <= 1'b1;
                  sd_q     <= 1'b0;
               end
               OP_CTRL: begin
                  unique case (sub)
                     3'b000, 3'b001: ;
                     3'b010, 3'b011: if (pdl) sd_q <= 1'b1;
                     3'b100:         upo_q  <= 1'b0;
                     3'b101:         upo_q  <= 1'b1;
                     3'b110:         late_q <= 1'b1;
                     3'b111:         late_q <= 1'b0;
                  endcase
               end
            endcase
         end
         if (shdn && pdl) sd_q <= 1'b1;
         if (pdl_fall)    sd_q <= 1'b0;
         if (!clr_n) begin
            dac_live <= 1'b0;
            upo_q    <= 1'b0;
         end
      end
   end

   assign dac_code  = dac_live ? dac_q : rst_code;
   assign shutdown  = sd_q;
   assign upo       = upo_q;
   assign mode_late = late_q;

endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
   import serdac_pkg::*;
#(
   parameter int DATA_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic              shdn,
   input  logic              pdl,
   input  logic              clr_n,
   input  logic              rs,
   output logic [DATA_W-1:0] dac_code,
   output logic              shutdown,
   output logic              upo,
   output logic              dout
);

   localparam int FW = DATA_W + 2;
   localparam int PW = $bits(pins_t);

   if (DATA_W < 4) begin : g_bad_width
      $error("serdac_frontend: DATA_W must be at least 4");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("serdac_frontend: SYNC_STAGES must lie in 0..4");
   end

   pins_t         raw, cur;
   logic          cs_prv, sclk_prv, pdl_prv;
   logic          pdl_s, clr_s, cs_s, pdl_fall;
   logic          frame_go, mode_late;
   logic [FW-1:0] word;

   assign raw = {cs_n, sclk, din, shdn, pdl, clr_n};

   serdac_sync #(.W(PW), .STAGES(SYNC_STAGES), .IDLE(PINS_IDLE)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (raw), .q (cur)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prv   <= PINS_IDLE.cs_n;
         sclk_prv <= PINS_IDLE.sclk;
         pdl_prv  <= PINS_IDLE.pdl;
      end else begin
         cs_prv   <= cur.cs_n;
         sclk_prv <= cur.sclk;
         pdl_prv  <= cur.pdl;
      end
   end

   assign pdl_s    = cur.pdl;
   assign clr_s    = cur.clr_n;
   assign cs_s     = cur.cs_n;
   assign pdl_fall = ~cur.pdl & pdl_prv;

   serdac_rx #(.FW(FW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cur.cs_n),
      .cs_n_prv  (cs_prv),
      .sclk      (cur.sclk),
      .sclk_prv  (sclk_prv),
      .din       (cur.din),
      .mode_late (mode_late),
      .hold      (shutdown),
      .frame_go  (frame_go),
      .word      (word),
      .dout      (dout)
   );

   serdac_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_go  (frame_go),
      .word      (word),
      .pdl       (cur.pdl),
      .shdn      (cur.shdn),
      .pdl_fall  (pdl_fall),
      .clr_n     (cur.clr_n),
      .rs        (rs),
      .dac_code  (dac_code),
      .shutdown  (shutdown),
      .upo       (upo),
      .mode_late (mode_late)
   );

endmodule

// File: rtl/serdac_frontend_chk.sv
module serdac_frontend_chk #(
   parameter int DATA_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rs,
   input logic [DATA_W-1:0] dac_code,
   input logic              shutdown,
   input logic              upo,
   input logic              dout,
   input logic              pdl_s,
   input logic              clr_s,
   input logic              cs_s,
   input logic              frame_go
);

   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   // R8
   lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> $past(pdl_s));

   // R9
   pdl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdl_s) |=> !shutdown);

   // R4
   exit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown) |-> ($past(frame_go) || !$past(pdl_s)));

   // R10
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shutdown) |-> $stable(dout));

   // R11
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> (dac_code == (rs ? MID : '0)) && !upo);

   // R3
   dac_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_code) |-> ($past(frame_go) || !$past(clr_s) || !$stable(rs)));

   // R2
   go_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_go |=> cs_s || $past(cs_s));

endmodule

bind serdac_frontend serdac_frontend_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rs       (rs),
   .dac_code (dac_code),
   .shutdown (shutdown),
   .upo      (upo),
   .dout     (dout),
   .pdl_s    (pdl_s),
   .clr_s    (clr_s),
   .cs_s     (cs_s),
   .frame_go (frame_go)
);

// File: tb/tb_serdac_frontend.sv
module tb_serdac_frontend;

   localparam int DW   = 14;
   localparam int SS   = 2;
   localparam int FW   = DW + 2;
   localparam int HP   = 4;
   localparam int MID  = 1 << (DW - 1);
   localparam int MASK = (1 << DW) - 1;

   logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, din = 0;
   logic shdn = 0, pdl = 1, clr_n = 1, rs = 0;
   logic [DW-1:0] dac_code;
   logic shutdown, upo, dout;

   int    checks = 0, fails = 0;
   string req = "R12";
   bit    done = 0;

   always #10 clk = ~clk;

   serdac_frontend #(.DATA_W(DW), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .shdn(shdn), .pdl(pdl), .clr_n(clr_n), .rs(rs),
      .dac_code(dac_code), .shutdown(shutdown), .upo(upo), .dout(dout)
   );

   // reference model state; -1 stands for "reset code, follows rs"
   int m_in, m_dac, m_cnt;
   bit m_sd, m_upo, m_late, m_dout;
   bit q_bits[$];
   bit h_cs[$], h_sclk[$], h_din[$], h_shdn[$], h_pdl[$], h_clr[$];

   function automatic int resolve(int v);
      return (v < 0) ? (rs ? MID : 0) : v;
   endfunction

   task automatic model_reset();
      m_in = -1; m_dac = -1; m_cnt = 0;
      m_sd = 0; m_upo = 0; m_late = 0; m_dout = 0;
      q_bits.delete();
      h_cs.delete(); h_sclk.delete(); h_din.delete();
      h_shdn.delete(); h_pdl.delete(); h_clr.delete();
      for (int i = 0; i <= SS; i++) begin
         h_cs.push_back(1); h_sclk.push_back(0); h_din.push_back(0);
         h_shdn.push_back(0); h_pdl.push_back(0); h_clr.push_back(1);
      end
   endtask

   task automatic model_step();
      bit c_cs, c_sclk, c_din, c_shdn, c_pdl, c_clr, p_cs, p_sclk, p_pdl;
      bit rise, fall, csr, go;
      int word, op, sub, s;
      h_cs.push_back(cs_n); h_sclk.push_back(sclk); h_din.push_back(din);
      h_shdn.push_back(shdn); h_pdl.push_back(pdl); h_clr.push_back(clr_n);
      // R13: action uses pins sampled SS edges ago
      c_cs = h_cs[1]; c_sclk = h_sclk[1]; c_din = h_din[1];
      c_shdn = h_shdn[1]; c_pdl = h_pdl[1]; c_clr = h_clr[1];
      p_cs = h_cs[0]; p_sclk = h_sclk[0]; p_pdl = h_pdl[0];
      h_cs.delete(0); h_sclk.delete(0); h_din.delete(0);
      h_shdn.delete(0); h_pdl.delete(0); h_clr.delete(0);

      rise = c_sclk && !p_sclk;
      fall = !c_sclk && p_sclk;
      csr  = c_cs && !p_cs;
      go   = csr && (m_cnt > 0) && ((m_cnt % FW) == 0);
      word = 0;
      if (go) for (int i = 0; i < FW; i++) word = (word << 1) | int'(q_bits[i]);
      s = q_bits.size();
      if (!m_sd) begin
         if (!m_late && rise && !c_cs) m_dout = (s >= FW - 1) ? q_bits[s-(FW-1)] : 1'b0;
         else if (m_late && fall)      m_dout = (s >= FW) ? q_bits[s-FW] : 1'b0;
      end
      if (c_cs) m_cnt = 0;
      else if (rise) begin
         q_bits.push_back(c_din);
         if (q_bits.size() > FW) q_bits.delete(0);
         m_cnt++;
      end
      if (go) begin
         op = (word >> (FW - 2)) & 3;
         case (op)
            0: m_in = word & MASK;
            1: begin m_dac = resolve(m_in); m_sd = 0; end
            2: begin m_in = word & MASK; m_dac = word & MASK; m_sd = 0; end
            default: begin
               sub = (word >> (DW - 3)) & 7;
               case (sub)
                  2, 3: if (c_pdl) m_sd = 1;
                  4: m_upo = 0;
                  5: m_upo = 1;
                  6: m_late = 1;
                  7: m_late = 0;
                  default: ;
               endcase
            end
         endcase
      end
      if (c_shdn && c_pdl) m_sd = 1;
      if (!c_pdl && p_pdl) m_sd = 0;
      if (!c_clr) begin m_dac = -1; m_upo = 0; end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   // per-clock comparison, a quarter period after the edge
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         checks++;
         if (dac_code !== DW'(resolve(m_dac)) || shutdown !== m_sd ||
             upo !== m_upo || dout !== m_dout) begin
            fails++;
            $display("FAIL %s per-clock: dac=%h sd=%b upo=%b dout=%b expected dac=%h sd=%b upo=%b dout=%b",
                     req, dac_code, shutdown, upo, dout, DW'(resolve(m_dac)), m_sd, m_upo, m_dout);
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s directed: actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic send(input logic [63:0] bits, input int n, input int gap);
      cs_n = 0;
      wait_clk(HP);
      for (int i = 0; i < n; i++) begin
         din = bits[n-1-i];
         wait_clk(HP);
         sclk = 1;
         wait_clk(HP);
         sclk = 0;
         if (gap > 0 && i + 1 == gap) wait_clk(4 * HP);
      end
      wait_clk(HP);
      cs_n = 1;
      din  = 0;
      wait_clk(3 * HP);
   endtask

   task automatic clocks_cs_high(input logic [15:0] bits);
      for (int i = 0; i < 16; i++) begin
         din = bits[15-i];
         wait_clk(HP);
         sclk = 1;
         wait_clk(HP);
         sclk = 0;
      end
      din = 0;
      wait_clk(3 * HP);
   endtask

   initial begin
      logic held;
      wait_clk(3);
      rst_n = 1;
      wait_clk(4);
      // R12 reset state with rs low
      req = "R12";
      chk("R12", dac_code, 0); chk("R12", shutdown, 0);
      chk("R12", upo, 0);      chk("R12", dout, 0);

      req = "R3";
      send({2'b00, 14'h1234}, 16, 0);
      chk("R3", dac_code, 0);
      req = "R4";
      send(64'h4000, 16, 0);
      chk("R4", dac_code, 'h1234);
      req = "R5";
      send({2'b10, 14'h3FFF}, 16, 0);
      chk("R5", dac_code, 'h3FFF);

      req = "R2";
      send({2'b10, 14'h0555}, 16, 8);
      chk("R2", dac_code, 'h0555);
      send({2'b10, 14'h0AAA} >> 1, 15, 0);
      chk("R2", dac_code, 'h0555);
      send({1'b0, 2'b10, 14'h0AAA}, 17, 0);
      chk("R2", dac_code, 'h0555);
      send({2'b10, 14'h0AAA, 2'b10, 14'h0123}, 32, 0);
      chk("R2", dac_code, 'h0123);

      req = "R1";
      clocks_cs_high({2'b10, 14'h3333});
      chk("R1", dac_code, 'h0123);
      send({2'b10, 14'h0F0F}, 16, 0);
      chk("R1", dac_code, 'h0F0F);

      req = "R6";
      send(64'hE800, 16, 0);
      chk("R6", upo, 1);
      send(64'hE000, 16, 0);
      chk("R6", upo, 0);
      send(64'hE800, 16, 0);
      send(64'hC000, 16, 0);
      chk("R6", upo, 1); chk("R6", dac_code, 'h0F0F);

      req = "R7";
      send(64'hF000, 16, 0);
      send(64'h0001, 16, 0);
      chk("R7", dout, 0);
      send(64'h8005, 16, 0);
      chk("R7", dout, 1);
      chk("R7", dac_code, 5);
      send(64'hF800, 16, 0);
      send(64'h8006, 16, 0);
      chk("R7", dout, 1);

      req = "R8";
      shdn = 1; wait_clk(6); shdn = 0; wait_clk(6);
      chk("R8", shutdown, 1);
      req = "R10";
      held = dout;
      send({2'b00, 14'h0222}, 16, 0);
      chk("R10", shutdown, 1); chk("R10", dac_code, 6);
      chk("R10", dout, held);  chk("R10", upo, 1);
      req = "R4";
      send(64'h4000, 16, 0);
      chk("R4", shutdown, 0); chk("R4", dac_code, 'h0222);

      req = "R9";
      send(64'hD000, 16, 0);
      chk("R9", shutdown, 1);
      pdl = 0; wait_clk(6);
      chk("R9", shutdown, 0);
      req = "R8";
      shdn = 1; wait_clk(6); shdn = 0; wait_clk(6);
      chk("R8", shutdown, 0);
      send(64'hD000, 16, 0);
      chk("R8", shutdown, 0);
      pdl = 1; wait_clk(6);

      req = "R5";
      send(64'hD000, 16, 0);
      send({2'b10, 14'h1111}, 16, 0);
      chk("R5", shutdown, 0); chk("R5", dac_code, 'h1111);

      req = "R11";
      rs = 1; wait_clk(2);
      clr_n = 0; wait_clk(6);
      chk("R11", dac_code, MID); chk("R11", upo, 0);
      clr_n = 1; wait_clk(6);
      send(64'h4000, 16, 0);
      chk("R11", dac_code, 'h1111);

      req = "R12";
      rst_n = 0; wait_clk(3); rst_n = 1; wait_clk(4);
      chk("R12", dac_code, MID); chk("R12", shutdown, 0);
      send(64'h4000, 16, 0);
      chk("R12", dac_code, MID);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL %s watchdog expired", req);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule